// File: doc/BRIEF.md
# Merging and Gathering Write Buffer

This block sits between a processor's store port and a memory controller and holds write traffic back for a while, so that memory sees fewer and longer transfers. Repeated stores to one word address are folded into a single pending word by combining their byte enables. Stores that walk upward through consecutive word addresses are collected into one burst of up to eight words.

Each store carries two attributes. One says whether the store is cacheable. The other is a 3-bit attribute code. Stores that are not eligible for folding or collecting bypass that machinery. Any pending entry is pushed out first, and then the store itself goes out as a one-word transfer.

The memory side presents a stable start address and beat count for the whole burst. It then streams one data word and its byte enables per accepted beat. A flush input pushes out whatever is pending.

Top module: `write_gather_buffer`

## Requirements
- R1: A store is eligible when `inCached` is 1, or when `inAttr` equals 7. Any other uncached store, for example one with `inAttr` = 6, is not eligible.
- R2: An eligible store to the word address of the pending word is folded into it. The byte enables are ORed, and each byte lane whose new enable is 1 takes the new data. The result leaves as a single beat.
- R3: While every store goes to the pending word or to the next sequential word, and no flush is raised, `memValid` stays 0.
- R4: Eligible stores to consecutive word addresses form one burst. `memStartAddr` is the first word, `memBeats` is the word count, and the beats come out in ascending address order.
- R5: A burst holds at most 8 words and never spans an 8-word aligned address boundary. A store to the word just past that boundary starts a new burst.
- R6: An eligible store to any other address is refused (`inReady` = 0) in the cycle it is presented. The pending burst has `memValid` = 1 from the next cycle. After the burst drains, the store is accepted as the start of a new entry.
- R7: A non-eligible store first releases any pending entry. It is then sent alone with `memBeats` = 1, its data and byte enables unchanged, in program order.
- R8: A `flush` pulse while an entry is pending gives `memValid` = 1 in the next cycle, with every collected word in the burst. A flush with nothing pending produces no transfer.
- R9: While `memValid` = 1 and `memReady` = 0, the beat data, start address and beat count hold. `memLast` is 1 on the final beat only. `inReady` is 0 while a burst drains.
- R10: After reset, `memValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Store request valid |
| inReady | output | 1 | Store request accepted this cycle |
| inAddr | input | ADDR_W | Word address of the store |
| inData | input | DATA_W | Store data |
| inBe | input | DATA_W/8 | Byte lane enables |
| inCached | input | 1 | Store is cacheable |
| inAttr | input | 3 | Attribute code of an uncached store |
| flush | input | 1 | Push out the pending entry |
| memValid | output | 1 | Burst beat valid |
| memReady | input | 1 | Memory accepts the beat |
| memStartAddr | output | ADDR_W | Word address of the first beat |
| memBeats | output | log2(MAX_BEATS)+1 | Number of beats in the burst |
| memData | output | DATA_W | Beat data |
| memBe | output | DATA_W/8 | Beat byte enables |
| memLast | output | 1 | Final beat of the burst |

## Verification
An accepted store updates the buffer at the clock edge where it is taken, so nothing is visible on the memory side until a release. A release happens through a refused store, a non-eligible store or a flush. It raises `memValid` at the first edge after the trigger, and each beat then advances on an edge where `memValid` and `memReady` are both 1. The bench drives inputs just after a rising edge and samples on the falling edge. The refusal is therefore checked in the trigger's own cycle, and the first beat in the following half-period. A monitor records every accepted beat on falling edges, and the recorded stream is compared word for word against the expected bursts. Data is compared only on enabled lanes.

// File: rtl/wgb_pkg.sv
package wgb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_DRAIN = 2'd2
  } wgbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // write the selected slot
    logic wrFresh;  // slot starts a new word (enables replaced, not ORed)
  } wgbStrobe_t;

endpackage

// File: rtl/wgb_slot.sv
module wgb_slot #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                we,
  input  logic                fresh,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wBe,
  output logic [DATA_W-1:0]   qData,
  output logic [DATA_W/8-1:0] qBe
);
  localparam int LANES = DATA_W / 8;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qData <= '0;
      qBe   <= '0;
    end else if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wBe[l]) qData[l*8 +: 8] <= wData[l*8 +: 8];
      end
      qBe <= fresh ? wBe : (qBe | wBe);
    end
  end
endmodule

// File: rtl/wgb_data.sv
module wgb_data
  import wgb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  wgbStrobe_t                   strobe,
  input  logic [$clog2(MAX_BEATS)-1:0] wrSlot,
  input  logic [$clog2(MAX_BEATS)-1:0] rdSlot,
  input  logic [DATA_W-1:0]            inData,
  input  logic [DATA_W/8-1:0]          inBe,
  output logic [DATA_W-1:0]            memData,
  output logic [DATA_W/8-1:0]          memBe
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] slotData [MAX_BEATS];
  logic [LANES-1:0]  slotBe   [MAX_BEATS];

  for (genvar s = 0; s < MAX_BEATS; s++) begin : g_slot
    logic slotWe;
    assign slotWe = strobe.wrEn && (wrSlot == s);
    wgb_slot #(.DATA_W(DATA_W)) i_slot (
      .clk   (clk),
      .rstN  (rstN),
      .we    (slotWe),
      .fresh (strobe.wrFresh),
      .wData (inData),
      .wBe   (inBe),
      .qData (slotData[s]),
      .qBe   (slotBe[s])
    );
  end

  assign memData = slotData[rdSlot];
  assign memBe   = slotBe[rdSlot];
endmodule

// File: rtl/wgb_ctrl.sv
module wgb_ctrl
  import wgb_pkg::*;
#(
  parameter int ADDR_W      = 30,
  parameter int MAX_BEATS   = 8,
  parameter int GATHER_ATTR = 7
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic [ADDR_W-1:0]              inAddr,
  input  logic                           inCached,
  input  logic [2:0]                     inAttr,
  input  logic                           flush,
  input  logic                           memReady,
  output logic                           inReady,
  output logic                           memValid,
  output logic [ADDR_W-1:0]              memStartAddr,
  output logic [$clog2(MAX_BEATS):0]     memBeats,
  output logic                           memLast,
  output logic                           entryOpen,
  output wgbStrobe_t                     strobe,
  output logic [$clog2(MAX_BEATS)-1:0]   wrSlot,
  output logic [$clog2(MAX_BEATS)-1:0]   rdSlot
);
  localparam int OFF_W = $clog2(MAX_BEATS);
  localparam int CNT_W = OFF_W + 1;

  wgbState_e         state, stateNxt;
  logic [ADDR_W-1:0] startAddr, startNxt;
  logic [OFF_W-1:0]  lastOff, lastOffNxt;
  logic [OFF_W-1:0]  beatIdx, beatNxt;

  logic              eligible, hitSame, hitNext;
  logic [ADDR_W-1:0] lastAddr, nextAddr;

  assign eligible = inCached || (inAttr == 3'(GATHER_ATTR));
  assign lastAddr = startAddr + ADDR_W'(lastOff);
  assign nextAddr = lastAddr + ADDR_W'(1);
  assign hitSame  = (inAddr == lastAddr);
  assign hitNext  = (inAddr == nextAddr) && (inAddr[OFF_W-1:0] != '0);

  always_comb begin
    stateNxt   = state;
    startNxt   = startAddr;
    lastOffNxt = lastOff;
    beatNxt    = beatIdx;
    inReady    = 1'b0;
    strobe     = '0;
    wrSlot     = '0;
    unique case (state)
      ST_IDLE: begin
        inReady = !flush;
        if (inValid && !flush) begin
          strobe.wrEn    = 1'b1;
          strobe.wrFresh = 1'b1;
          wrSlot         = '0;
          startNxt       = inAddr;
          lastOffNxt     = '0;
          beatNxt        = '0;
          stateNxt       = eligible ? ST_OPEN : ST_DRAIN;
        end
      end
      ST_OPEN: begin
        if (flush) begin
          beatNxt  = '0;
          stateNxt = ST_DRAIN;
        end else if (inValid) begin
          if (eligible && hitSame) begin
            inReady        = 1'b1;
            strobe.wrEn    = 1'b1;
            strobe.wrFresh = 1'b0;
            wrSlot         = lastOff;
          end else if (eligible && hitNext) begin
            inReady        = 1'b1;
            strobe.wrEn    = 1'b1;
            strobe.wrFresh = 1'b1;
            wrSlot         = lastOff + OFF_W'(1);
            lastOffNxt     = lastOff + OFF_W'(1);
          end else begin
            beatNxt  = '0;
            stateNxt = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (memReady) begin
          if (beatIdx == lastOff) stateNxt = ST_IDLE;
          else                    beatNxt  = beatIdx + OFF_W'(1);
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startAddr <= '0;
      lastOff   <= '0;
      beatIdx   <= '0;
    end else begin
      state     <= stateNxt;
      startAddr <= startNxt;
      lastOff   <= lastOffNxt;
      beatIdx   <= beatNxt;
    end
  end

  assign memValid     = (state == ST_DRAIN);
  assign memStartAddr = startAddr;
  assign memBeats     = CNT_W'(lastOff) + CNT_W'(1);
  assign memLast      = memValid && (beatIdx == lastOff);
  assign rdSlot       = beatIdx;
  assign entryOpen    = (state == ST_OPEN);
endmodule

// File: rtl/write_gather_buffer.sv
module write_gather_buffer
  import wgb_pkg::*;
#(
  parameter int ADDR_W      = 30,
  parameter int DATA_W      = 32,
  parameter int MAX_BEATS   = 8,
  parameter int GATHER_ATTR = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [ADDR_W-1:0]          inAddr,
  input  logic [DATA_W-1:0]          inData,
  input  logic [DATA_W/8-1:0]        inBe,
  input  logic                       inCached,
  input  logic [2:0]                 inAttr,
  input  logic                       flush,
  output logic                       memValid,
  input  logic                       memReady,
  output logic [ADDR_W-1:0]          memStartAddr,
  output logic [$clog2(MAX_BEATS):0] memBeats,
  output logic [DATA_W-1:0]          memData,
  output logic [DATA_W/8-1:0]        memBe,
  output logic                       memLast
);
  localparam int OFF_W = $clog2(MAX_BEATS);

  wgbStrobe_t       strobe;
  logic [OFF_W-1:0] wrSlot, rdSlot;
  logic             entryOpen;

  wgb_ctrl #(
    .ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS), .GATHER_ATTR(GATHER_ATTR)
  ) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inAddr       (inAddr),
    .inCached     (inCached),
    .inAttr       (inAttr),
    .flush        (flush),
    .memReady     (memReady),
    .inReady      (inReady),
    .memValid     (memValid),
    .memStartAddr (memStartAddr),
    .memBeats     (memBeats),
    .memLast      (memLast),
    .entryOpen    (entryOpen),
    .strobe       (strobe),
    .wrSlot       (wrSlot),
    .rdSlot       (rdSlot)
  );

  wgb_data #(.DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrSlot  (wrSlot),
    .rdSlot  (rdSlot),
    .inData  (inData),
    .inBe    (inBe),
    .memData (memData),
    .memBe   (memBe)
  );
endmodule

// File: rtl/wgb_checker.sv
module wgb_checker #(
  parameter int ADDR_W      = 30,
  parameter int DATA_W      = 32,
  parameter int MAX_BEATS   = 8,
  parameter int GATHER_ATTR = 7
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic                       inReady,
  input logic                       inCached,
  input logic [2:0]                 inAttr,
  input logic                       flush,
  input logic                       entryOpen,
  input logic                       memValid,
  input logic                       memReady,
  input logic [ADDR_W-1:0]          memStartAddr,
  input logic [$clog2(MAX_BEATS):0] memBeats,
  input logic [DATA_W-1:0]          memData
);
  localparam int OFF_W = $clog2(MAX_BEATS);

  logic [ADDR_W-1:0] endAddr;
  logic              storeOk;
  assign endAddr = memStartAddr + ADDR_W'(memBeats) - ADDR_W'(1);
  assign storeOk = inCached || (inAttr == 3'(GATHER_ATTR));

  a_r4_beats_range: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memBeats >= 1) && (memBeats <= MAX_BEATS));

  a_r5_no_cross: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memStartAddr[ADDR_W-1:OFF_W] == endAddr[ADDR_W-1:OFF_W]));

  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memData)
      && $stable(memStartAddr) && $stable(memBeats));

  a_r9_no_accept_drain: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !inReady);

  a_r7_single_beat: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && !storeOk |=> memValid && (memBeats == 1));

  a_r8_flush_out: assert property (@(posedge clk) disable iff (!rstN)
    flush && entryOpen |=> memValid);

  a_r3_held: assert property (@(posedge clk) disable iff (!rstN)
    entryOpen && !flush && !(inValid && !inReady) |=> !memValid);
endmodule

bind write_gather_buffer wgb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .GATHER_ATTR(GATHER_ATTR)
) i_wgb_checker (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .inReady      (inReady),
  .inCached     (inCached),
  .inAttr       (inAttr),
  .flush        (flush),
  .entryOpen    (entryOpen),
  .memValid     (memValid),
  .memReady     (memReady),
  .memStartAddr (memStartAddr),
  .memBeats     (memBeats),
  .memData      (memData)
);

// File: tb/test_write_gather_buffer.sv
`timescale 1ns/1ps
module test_write_gather_buffer;
  localparam int ADDR_W = 30;
  localparam int DATA_W = 32;
  localparam int MAXB   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0, inReady;
  logic [ADDR_W-1:0] inAddr = '0;
  logic [DATA_W-1:0] inData = '0;
  logic [3:0]        inBe = '0;
  logic              inCached = 1'b0;
  logic [2:0]        inAttr = '0;
  logic              flush = 1'b0;
  logic              memValid, memReady = 1'b1, memLast;
  logic [ADDR_W-1:0] memStartAddr;
  logic [3:0]        memBeats;
  logic [DATA_W-1:0] memData;
  logic [3:0]        memBe;

  always #2 clk = ~clk;

  write_gather_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BEATS(MAXB)) i_write_gather_buffer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .inData(inData), .inBe(inBe), .inCached(inCached), .inAttr(inAttr), .flush(flush),
    .memValid(memValid), .memReady(memReady), .memStartAddr(memStartAddr),
    .memBeats(memBeats), .memData(memData), .memBe(memBe), .memLast(memLast)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // beat monitor
  logic [ADDR_W-1:0] capAddr [64];
  logic [3:0]        capBeats[64];
  logic [DATA_W-1:0] capData [64];
  logic [3:0]        capBe   [64];
  logic              capLast [64];
  int capN = 0;
  always @(negedge clk) begin
    if (rstN && memValid && memReady && capN < 64) begin
      capAddr[capN]  = memStartAddr;
      capBeats[capN] = memBeats;
      capData[capN]  = memData;
      capBe[capN]    = memBe;
      capLast[capN]  = memLast;
      capN++;
    end
  end

  // stimulus: {addr[55:40], data[39:8], be[7:4], cached[3], attr[2:0]}
  localparam logic [55:0] WR_TAB [10] = '{
    56'h0040_11111111_F_8, 56'h0040_0000AA00_2_8, 56'h0041_22222222_3_7,
    56'h0041_33330000_C_8, 56'h0042_44444444_1_7, 56'h0050_55555555_F_8,
    56'h0060_66666666_F_6, 56'h007E_00000077_F_8, 56'h007F_00000088_F_7,
    56'h0080_00000099_F_8
  };
  // expected beats: {addr[55:40], beats[39:36], data[35:4], be[3:0]}
  localparam logic [55:0] EX_TAB [8] = '{
    56'h0040_3_1111AA11_F, 56'h0040_3_33332222_F, 56'h0040_3_00000044_1,
    56'h0050_1_55555555_F, 56'h0060_1_66666666_F, 56'h007E_2_00000077_F,
    56'h007E_2_00000088_F, 56'h0080_1_00000099_F
  };

  task automatic drive(input logic [15:0] a, input logic [31:0] d, input logic [3:0] b,
                       input logic c, input logic [2:0] at);
    inAddr = ADDR_W'(a); inData = d; inBe = b; inCached = c; inAttr = at; inValid = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] b,
                    input logic c, input logic [2:0] at);
    @(posedge clk); #1;
    drive(a, d, b, c, at);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic doFlush();
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
  endtask

  function automatic logic [31:0] laneMask(input logic [3:0] b);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{b[l]}};
    return m;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(memValid == 1'b0, "R10 memValid after reset", 64'(memValid), 0);
    chk(inReady == 1'b1, "R10 inReady after reset", 64'(inReady), 1);

    // vector table: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < 10; i++)
      wr(WR_TAB[i][55:40], WR_TAB[i][39:8], WR_TAB[i][7:4], WR_TAB[i][3], WR_TAB[i][2:0]);
    doFlush();
    repeat (6) @(negedge clk);
    chk(capN == 8, "R4 beat count of table run", 64'(capN), 8);
    begin
      int pos = 0;
      for (int i = 0; i < 8; i++) begin
        logic [31:0] m;
        m = laneMask(EX_TAB[i][3:0]);
        chk(capAddr[i] == ADDR_W'(EX_TAB[i][55:40]) && capBeats[i] == EX_TAB[i][39:36],
            "R4 R5 R6 R7 burst address/length", {capAddr[i][15:0], 12'h0, capBeats[i]},
            {EX_TAB[i][55:40], 12'h0, EX_TAB[i][39:36]});
        chk(((capData[i] & m) == (EX_TAB[i][35:4] & m)) && capBe[i] == EX_TAB[i][3:0],
            "R1 R2 beat data/enables", {capData[i], 28'h0, capBe[i]}, {EX_TAB[i][35:4], 28'h0, EX_TAB[i][3:0]});
        chk(capLast[i] == (pos == int'(EX_TAB[i][39:36]) - 1), "R9 memLast position",
            64'(capLast[i]), 64'(pos == int'(EX_TAB[i][39:36]) - 1));
        pos = (pos == int'(EX_TAB[i][39:36]) - 1) ? 0 : pos + 1;
      end
    end

    // full aligned 8-word burst, held until flush (R3), stall (R8 R9)
    base = capN;
    for (int i = 0; i < 8; i++) wr(16'h0100 + 16'(i), 32'hA0 + 32'(i), 4'hF, 1'b1, 3'd0);
    repeat (3) @(negedge clk);
    chk(memValid == 1'b0 && capN == base, "R3 entry held without release", 64'(capN), 64'(base));
    @(posedge clk); #1 memReady = 1'b0; flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    chk(memValid == 1'b1, "R8 flush releases next cycle", 64'(memValid), 1);
    chk(memBeats == 4'd8 && memStartAddr == ADDR_W'(16'h0100), "R5 full 8-beat burst",
        {memStartAddr, memBeats}, {30'h100, 4'd8});
    chk(inReady == 1'b0, "R9 no accept while draining", 64'(inReady), 0);
    held = memData;
    repeat (3) @(negedge clk);
    chk(memValid == 1'b1 && memData == held, "R9 beat held under stall", 64'(memData), 64'(held));
    @(posedge clk); #1 memReady = 1'b1;
    repeat (10) @(negedge clk);
    chk(capN == base + 8, "R5 eight beats drained", 64'(capN), 64'(base + 8));
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 8; i++) if (capData[base+i] != 32'hA0 + 32'(i)) ok = 1'b0;
      chk(ok, "R4 ascending beat order", 64'(capData[base+7]), 64'hA7);
    end

    // release timing on non-sequential store (R6)
    base = capN;
    wr(16'h0200, 32'hCAFE0001, 4'hF, 1'b1, 3'd0);
    @(posedge clk); #1 drive(16'h0300, 32'hCAFE0002, 4'hF, 1'b1, 3'd0);
    @(negedge clk);
    chk(inReady == 1'b0, "R6 non-sequential store refused", 64'(inReady), 0);
    @(negedge clk);
    chk(memValid == 1'b1 && memStartAddr == ADDR_W'(16'h0200) && memBeats == 4'd1,
        "R6 pending burst out next cycle", {memStartAddr, memBeats}, {30'h200, 4'd1});
    while (!inReady) @(negedge clk);
    @(posedge clk); #1 inValid = 1'b0;
    doFlush();
    repeat (4) @(negedge clk);
    chk(capN == base + 2 && capAddr[base+1] == ADDR_W'(16'h0300), "R6 refused store becomes new entry",
        64'(capAddr[base+1]), 64'h300);

    // flush with nothing pending (R8)
    base = capN;
    doFlush();
    repeat (4) @(negedge clk);
    chk(capN == base && memValid == 1'b0, "R8 empty flush no transfer", 64'(capN), 64'(base));

    // uncached attr 6 alone: no merge of a second store to same word (R1 R7)
    base = capN;
    wr(16'h0400, 32'h000000AB, 4'h1, 1'b0, 3'd6);
    wr(16'h0400, 32'h0000CD00, 4'h2, 1'b0, 3'd6);
    repeat (4) @(negedge clk);
    chk(capN == base + 2 && capBeats[base] == 4'd1 && capBe[base+1] == 4'h2,
        "R7 non-eligible stores stay single", {32'(capN - base), 28'h0, capBe[base+1]}, {32'd2, 28'h0, 4'h2});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule